// File: doc/BRIEF.md
# Deglitched Timing-Window Edge Calibrator

This block finds where a timing-error indicator turns on and off as a tag offset is swept, and then places the offset in the middle of the window where no error is reported. An outside skew tester supplies the indicator. For each trial the block drives a new offset, pulses a one-cycle sample request, and waits for a sample-valid handshake that carries one error bit. The handshake stands in for the settle and test delays, which sit outside the block. A search engine moves through three phases, SETTLE, SEEK and CONFIRM, so that an isolated sample of the wrong level cannot fix an edge in place.

A calibration runs two searches in turn. The first search starts at offset 0 and looks for the error bit rising to 1. The second search starts at the last offset the first one applied and looks for the error bit falling to 0. The centre of the passing window is worked out from the two edges and then driven on the offset output. The block reports busy while it works, gives a one-cycle done pulse at the end, and raises a fail flag if either search uses up its step budget.

The control FSM has the states CAL_IDLE, CAL_RISE and CAL_FALL. Its transitions are: IDLE→RISE on start; RISE→FALL when the rising search succeeds; RISE→IDLE when the rising search fails; FALL→IDLE when the falling search ends. The engine FSM has the states ENG_IDLE, ENG_REQ and ENG_WAIT. Its transitions are: IDLE→REQ on start; REQ→WAIT always; WAIT→REQ on a sample that ends nothing; WAIT→IDLE on a confirm or on the last budgeted sample. The phase transitions are: SETTLE→SEEK after the run of stable samples; SEEK→CONFIRM on the first sample at the target level; CONFIRM ends the search after the run of stable samples.

Top module: `edge_window_calibrator`

## Requirements
- R1: After reset, busy, done, fail and sample_req are 0, and tag_offset is 0.
- R2: sample_req is a single-cycle pulse. Within one search, the first request shows the search's base offset and each later request shows the previous offset plus 8. A sample is taken only while the engine is waiting, and it is the error bit for the offset that was shown with the request.
- R3: In SETTLE, an error bit different from the target raises a run counter and a bit equal to the target clears it. The tenth consecutive differing bit moves the search to SEEK and clears the counter. An error bit of 1 means a timing error.
- R4: In SEEK, the first bit equal to the target moves the search to CONFIRM. The edge is recorded as the sampled offset plus 8.
- R5: In CONFIRM, a bit different from the target adds 8 to the edge and clears the counter. A bit equal to the target raises the counter. The tenth consecutive equal bit ends the search with success and the current edge.
- R6: A search takes at most 4096 samples. If its last budgeted sample does not confirm an edge, the calibration ends with fail = 1. A confirm on that last sample counts as a success.
- R7: The rising search starts at offset 0 with target 1. The falling search uses target 0, and its first request repeats the last offset that the rising search applied.
- R8: On success, tag_offset becomes fall + w/2, with w = 32768 − (fall − rise). This is 32-bit signed arithmetic with division that truncates toward zero, and the result is presented as unsigned. rise_edge and fall_edge show the two edges.
- R9: busy is high from the cycle after start until done. done is a one-cycle pulse with busy low. fail holds until the next start. After a failure tag_offset is 0, and rise_edge keeps any rising edge that was found.
- R10: A start pulse received while busy has no effect on the calibration's requests or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start_i | input | 1 | Start a calibration (used only when idle) |
| sample_req_o | output | 1 | One-cycle request for an error sample |
| tag_offset_o | output | OFF_W | Trial offset while busy; calibrated centre (or 0) when idle |
| sample_valid_i | input | 1 | Error sample is valid this cycle |
| sample_err_i | input | 1 | Error bit, 1 = timing error |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle end-of-calibration pulse |
| fail_o | output | 1 | Last calibration ran out of step budget |
| rise_edge_o | output | OFF_W | Rising edge found |
| fall_edge_o | output | OFF_W | Falling edge found |

## Verification
A start captured at an edge shows the first request in the following cycle. A sample accepted at an edge shows the next request, with the offset advanced, one cycle later. The final sample of a calibration reaches the top-level done pulse two edges after it is accepted: one edge for the engine and one for the sequencer, and the centre offset appears in the same cycle as done. The bench therefore drives and samples only on falling edges. It answers each request one or two cycles later and polls done rather than counting cycles. It compares the offset that came with every request, and the edges and centre shown with the done pulse, against a bench model of the sweep.

// File: rtl/edge_cal_pkg.sv
package edge_cal_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_REQ,
        ENG_WAIT
    } eng_state_t;

    typedef enum logic [1:0] {
        PH_SETTLE,
        PH_SEEK,
        PH_CONFIRM
    } phase_t;

    typedef enum logic [1:0] {
        CAL_IDLE,
        CAL_RISE,
        CAL_FALL
    } cal_state_t;

endpackage

// File: rtl/edge_deglitch.sv
module edge_deglitch
    import edge_cal_pkg::*;
#(
    parameter int OFF_W    = 32,
    parameter int STEP     = 8,
    parameter int STABLE_N = 10,
    parameter int CNT_W    = $clog2(STABLE_N + 1)
) (
    input  phase_t             phase_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [OFF_W-1:0]   edge_i,
    input  logic               hit_i,
    input  logic [OFF_W-1:0]   adv_off_i,
    output phase_t             phase_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [OFF_W-1:0]   edge_o,
    output logic               confirm_o
);

    localparam logic [CNT_W-1:0] LAST_RUN = CNT_W'(STABLE_N - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    always_comb begin
        phase_o   = phase_i;
        cnt_o     = cnt_i;
        edge_o    = edge_i;
        confirm_o = 1'b0;
        unique case (phase_i)
            PH_SETTLE: begin
                if (hit_i) begin
                    cnt_o = '0;
                end else if (cnt_i >= LAST_RUN) begin
                    phase_o = PH_SEEK;
                    cnt_o   = '0;
                end else begin
                    cnt_o = cnt_i + CNT_ONE;
                end
            end
            PH_SEEK: begin
                if (hit_i) begin
                    phase_o = PH_CONFIRM;
                    edge_o  = adv_off_i;
                end
            end
            PH_CONFIRM: begin
                if (!hit_i) begin
                    edge_o = edge_i + OFF_W'(STEP);
                    cnt_o  = '0;
                end else begin
                    cnt_o = cnt_i + CNT_ONE;
                    if (cnt_i >= LAST_RUN) begin
                        confirm_o = 1'b1;
                    end
                end
            end
            default: begin
                phase_o = PH_SETTLE;
                cnt_o   = '0;
            end
        endcase
    end

endmodule

// File: rtl/edge_seek_engine.sv
module edge_seek_engine
    import edge_cal_pkg::*;
#(
    parameter int OFF_W     = 32,
    parameter int STEP      = 8,
    parameter int MAX_STEPS = 4096,
    parameter int STABLE_N  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             target_i,
    input  logic [OFF_W-1:0] base_i,
    input  logic             smp_valid_i,
    input  logic             smp_err_i,
    output logic [OFF_W-1:0] offset_o,
    output logic             smp_req_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [OFF_W-1:0] edge_o
);

    localparam int CNT_W  = $clog2(STABLE_N + 1);
    localparam int STEP_W = $clog2(MAX_STEPS + 1);
    localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(MAX_STEPS - 1);

    eng_state_t        st_q, st_n;
    phase_t            ph_q, ph_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [OFF_W-1:0]  edge_q, edge_n;
    logic [OFF_W-1:0]  off_q;
    logic [STEP_W-1:0] steps_q;
    logic              tgt_q;
    logic              done_q;
    logic              fail_q;
    logic              confirm;
    logic              hit;
    logic              last_step;
    logic [OFF_W-1:0]  adv_off;

    assign hit       = (smp_err_i == tgt_q);
    assign adv_off   = off_q + OFF_W'(STEP);
    assign last_step = (steps_q == LAST_IDX);

    edge_deglitch #(
        .OFF_W   (OFF_W),
        .STEP    (STEP),
        .STABLE_N(STABLE_N),
        .CNT_W   (CNT_W)
    ) i_deglitch (
        .phase_i  (ph_q),
        .cnt_i    (cnt_q),
        .edge_i   (edge_q),
        .hit_i    (hit),
        .adv_off_i(adv_off),
        .phase_o  (ph_n),
        .cnt_o    (cnt_n),
        .edge_o   (edge_n),
        .confirm_o(confirm)
    );

    // next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ENG_IDLE: if (start_i) st_n = ENG_REQ;
            ENG_REQ:  st_n = ENG_WAIT;
            ENG_WAIT: begin
                if (smp_valid_i) begin
                    st_n = (confirm || last_step) ? ENG_IDLE : ENG_REQ;
                end
            end
            default:  st_n = ENG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ENG_IDLE;
        else        st_q <= st_n;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_SETTLE;
            cnt_q   <= '0;
            edge_q  <= '0;
            off_q   <= '0;
            steps_q <= '0;
            tgt_q   <= 1'b0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ENG_IDLE: begin
                    if (start_i) begin
                        off_q   <= base_i;
                        tgt_q   <= target_i;
                        ph_q    <= PH_SETTLE;
                        cnt_q   <= '0;
                        edge_q  <= '0;
                        steps_q <= '0;
                        fail_q  <= 1'b0;
                    end
                end
                ENG_REQ: begin
                end
                ENG_WAIT: begin
                    if (smp_valid_i) begin
                        ph_q    <= ph_n;
                        cnt_q   <= cnt_n;
                        edge_q  <= edge_n;
                        steps_q <= steps_q + STEP_W'(1);
                        if (confirm) begin
                            done_q <= 1'b1;
                        end else if (last_step) begin
                            done_q <= 1'b1;
                            fail_q <= 1'b1;
                        end else begin
                            off_q <= adv_off;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        smp_req_o = (st_q == ENG_REQ);
        busy_o    = (st_q != ENG_IDLE);
        done_o    = done_q;
        fail_o    = fail_q;
        edge_o    = edge_q;
        offset_o  = off_q;
    end

    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req_o |=> !smp_req_o);

    assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENG_REQ && $past(st_q) == ENG_WAIT) |-> off_q == $past(off_q) + OFF_W'(STEP));

    assert_budget_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        steps_q <= STEP_W'(MAX_STEPS));

    assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(STABLE_N));

    assert_edge_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_CONFIRM && $past(ph_q) == PH_CONFIRM) |-> edge_q >= $past(edge_q));

endmodule

// File: rtl/window_center.sv
module window_center #(
    parameter int OFF_W  = 32,
    parameter int PERIOD = 32768
) (
    input  logic [OFF_W-1:0] rise_i,
    input  logic [OFF_W-1:0] fall_i,
    output logic [OFF_W-1:0] center_o
);

    logic signed [OFF_W-1:0] span;
    logic signed [OFF_W-1:0] width;
    logic signed [OFF_W-1:0] half;
    logic        [OFF_W-1:0] round_up;

    always_comb begin
        span     = $signed(fall_i) - $signed(rise_i);
        width    = $signed(OFF_W'(PERIOD)) - span;
        // truncate toward zero: bias negatives by one before the shift
        round_up = {{(OFF_W-1){1'b0}}, width[OFF_W-1]};
        half     = $signed(width + $signed(round_up)) >>> 1;
        center_o = $unsigned($signed(fall_i) + half);
    end

endmodule

// File: rtl/edge_window_calibrator.sv
module edge_window_calibrator
    import edge_cal_pkg::*;
#(
    parameter int OFF_W    = 32,
    parameter int STEP     = 8,
    parameter int PERIOD   = 32768,
    parameter int STABLE_N = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_start_i,
    output logic             sample_req_o,
    output logic [OFF_W-1:0] tag_offset_o,
    input  logic             sample_valid_i,
    input  logic             sample_err_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [OFF_W-1:0] rise_edge_o,
    output logic [OFF_W-1:0] fall_edge_o
);

    localparam int MAX_STEPS = PERIOD / STEP;

    cal_state_t       cs_q, cs_n;
    logic [OFF_W-1:0] rise_q, fall_q, final_q;
    logic             done_q, fail_q;

    logic             eng_start, eng_tgt;
    logic [OFF_W-1:0] eng_base, eng_off, eng_edge, center;
    logic             eng_req, eng_busy, eng_done, eng_fail;

    always_comb begin
        eng_start = (cs_q == CAL_IDLE && cal_start_i) ||
                    (cs_q == CAL_RISE && eng_done && !eng_fail);
        eng_tgt   = (cs_q == CAL_IDLE);
        eng_base  = (cs_q == CAL_IDLE) ? '0 : eng_off;
    end

    edge_seek_engine #(
        .OFF_W    (OFF_W),
        .STEP     (STEP),
        .MAX_STEPS(MAX_STEPS),
        .STABLE_N (STABLE_N)
    ) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (eng_start),
        .target_i   (eng_tgt),
        .base_i     (eng_base),
        .smp_valid_i(sample_valid_i),
        .smp_err_i  (sample_err_i),
        .offset_o   (eng_off),
        .smp_req_o  (eng_req),
        .busy_o     (eng_busy),
        .done_o     (eng_done),
        .fail_o     (eng_fail),
        .edge_o     (eng_edge)
    );

    window_center #(
        .OFF_W (OFF_W),
        .PERIOD(PERIOD)
    ) i_center (
        .rise_i  (rise_q),
        .fall_i  (eng_edge),
        .center_o(center)
    );

    // next-state logic
    always_comb begin
        cs_n = cs_q;
        unique case (cs_q)
            CAL_IDLE: if (cal_start_i) cs_n = CAL_RISE;
            CAL_RISE: if (eng_done) cs_n = eng_fail ? CAL_IDLE : CAL_FALL;
            CAL_FALL: if (eng_done) cs_n = CAL_IDLE;
            default:  cs_n = CAL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= CAL_IDLE;
        else        cs_q <= cs_n;
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q  <= '0;
            fall_q  <= '0;
            final_q <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (cs_q)
                CAL_IDLE: begin
                    if (cal_start_i) begin
                        rise_q  <= '0;
                        fall_q  <= '0;
                        final_q <= '0;
                        fail_q  <= 1'b0;
                    end
                end
                CAL_RISE: begin
                    if (eng_done) begin
                        if (eng_fail) begin
                            done_q <= 1'b1;
                            fail_q <= 1'b1;
                        end else begin
                            rise_q <= eng_edge;
                        end
                    end
                end
                CAL_FALL: begin
                    if (eng_done) begin
                        done_q <= 1'b1;
                        if (eng_fail) begin
                            fail_q <= 1'b1;
                        end else begin
                            fall_q  <= eng_edge;
                            final_q <= center;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o       = (cs_q != CAL_IDLE);
        done_o       = done_q;
        fail_o       = fail_q;
        sample_req_o = eng_req;
        tag_offset_o = busy_o ? eng_off : final_q;
        rise_edge_o  = rise_q;
        fall_edge_o  = fall_q;
    end

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_fail_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !busy_o) |-> tag_offset_o == '0);

    assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req_o |-> busy_o);

    assert_engine_owned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> cs_q != CAL_IDLE);

endmodule

// File: tb/test_edge_window_calibrator.sv
`timescale 1ns/1ps
module test_edge_window_calibrator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_start_i = 1'b0;
    logic        sample_valid_i = 1'b0;
    logic        sample_err_i = 1'b0;
    logic        sample_req_o, busy_o, done_o, fail_o;
    logic [31:0] tag_offset_o, rise_edge_o, fall_edge_o;

    always #2.5 clk = ~clk;

    edge_window_calibrator i_edge_window_calibrator (
        .clk           (clk),
        .rst_n         (rst_n),
        .cal_start_i   (cal_start_i),
        .sample_req_o  (sample_req_o),
        .tag_offset_o  (tag_offset_o),
        .sample_valid_i(sample_valid_i),
        .sample_err_i  (sample_err_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .fail_o        (fail_o),
        .rise_edge_o   (rise_edge_o),
        .fall_edge_o   (fall_edge_o)
    );

    int checks = 0;
    int fails  = 0;

    // error-indicator model
    int unsigned zone_lo = 0, zone_hi = 0, glitch_mod = 0, glitch_seed = 0;
    bit          sticky = 1'b0;

    // responder bookkeeping
    int          smp_idx = 0, seq_bad = 0, n_rise = 0;

    function automatic bit err_at(input int unsigned off);
        int unsigned o;
        bit          e;
        o = off % 32768;
        if (sticky) e = (off >= zone_lo);
        else        e = (o >= zone_lo) && (o < zone_hi);
        if (glitch_mod != 0 && (((off >> 3) * 13 + glitch_seed) % glitch_mod) == 0) e = ~e;
        return e;
    endfunction

    function automatic void model(input int unsigned base, input bit tgt, output bit ok,
                                  output int unsigned edge_v, output int n, output int unsigned last);
        int unsigned off;
        int          ph, cnt;
        bit          e;
        off = base; ph = 0; cnt = 0; ok = 0; edge_v = 0; n = 0; last = base;
        for (int i = 0; i < 4096; i++) begin
            last = off;
            off  = off + 8;
            e    = err_at(last);
            n    = i + 1;
            if (ph == 0) begin
                if (e != tgt) cnt++; else cnt = 0;
                if (cnt >= 10) begin ph = 1; cnt = 0; end
            end else if (ph == 1) begin
                if (e == tgt) begin ph = 2; edge_v = off; end
            end else begin
                if (e != tgt) begin edge_v = edge_v + 8; cnt = 0; end
                else cnt++;
                if (cnt >= 10) begin ok = 1; return; end
            end
        end
    endfunction

    function automatic int unsigned center_of(input int unsigned r, input int unsigned f);
        int w;
        w = 32768 - (int'(f) - int'(r));
        return int'(f) + w / 2;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // sample responder: answers each request 1..2 cycles later
    task automatic serve();
        int unsigned off, exp_off;
        int          d;
        off     = tag_offset_o;
        exp_off = (smp_idx < n_rise) ? 8 * smp_idx : 8 * (smp_idx - 1);
        if (off != exp_off) seq_bad++;
        smp_idx++;
        d = 1 + int'($urandom % 2);
        repeat (d) @(negedge clk);
        sample_valid_i = 1'b1;
        sample_err_i   = err_at(off);
        @(negedge clk);
        sample_valid_i = 1'b0;
        sample_err_i   = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        forever begin
            if (sample_req_o) serve();
            else @(negedge clk);
        end
    end

    task automatic run_case(input bit poke_mid);
        bit          ok1, ok2, exp_fail;
        int unsigned e1, e2, l1, l2, exp_off;
        int          n1, n2;
        model(0, 1'b1, ok1, e1, n1, l1);
        ok2 = 0; e2 = 0; n2 = 0; l2 = 0;
        if (ok1) model(l1, 1'b0, ok2, e2, n2, l2);
        exp_fail = !ok1 || !ok2;
        exp_off  = exp_fail ? 0 : center_of(e1, e2);
        n_rise = n1; smp_idx = 0; seq_bad = 0;
        @(negedge clk) cal_start_i = 1'b1;
        @(negedge clk) cal_start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
        if (poke_mid) begin
            repeat (20) @(negedge clk);
            cal_start_i = 1'b1;            // R10: stray start while busy
            @(negedge clk) cal_start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        chk(busy_o == 1'b0, "R9", "busy with done", busy_o, 0);
        chk(fail_o == exp_fail, "R6", "fail flag", fail_o, exp_fail);
        if (ok1) chk(rise_edge_o == e1, "R4 R5", "rising edge", rise_edge_o, e1);
        if (!exp_fail) begin
            chk(fall_edge_o == e2, "R7", "falling edge", fall_edge_o, e2);
            chk(tag_offset_o == exp_off, "R8", "centre offset", tag_offset_o, exp_off);
        end else begin
            chk(tag_offset_o == 0, "R9", "offset after fail", tag_offset_o, 0);
        end
        chk(seq_bad == 0, "R2", "request offset sequence errors", seq_bad, 0);
        chk(smp_idx == n1 + n2, "R3 R6", "samples taken", smp_idx, n1 + n2);
        if (poke_mid) chk(smp_idx == n1 + n2, "R10", "stray start changed run", smp_idx, n1 + n2);
        @(negedge clk);
        chk(done_o == 1'b0, "R9", "done pulse width", done_o, 0);
        chk(fail_o == exp_fail, "R9", "fail held", fail_o, exp_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (4) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && fail_o == 0, "R1", "flags in reset",
            {busy_o, done_o, fail_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0, "R1", "busy", busy_o, 0);
        chk(done_o == 0, "R1", "done", done_o, 0);
        chk(fail_o == 0, "R1", "fail", fail_o, 0);
        chk(sample_req_o == 0, "R1", "sample_req", sample_req_o, 0);
        chk(tag_offset_o == 0, "R1", "tag_offset", tag_offset_o, 0);

        // directed: clean window
        zone_lo = 800; zone_hi = 2000; glitch_mod = 0; sticky = 0;
        run_case(1'b0);
        // directed: glitches around both edges (R3 R5 deglitch)
        zone_lo = 1200; zone_hi = 3100; glitch_mod = 9; glitch_seed = 4;
        run_case(1'b0);
        // directed: stray start while busy
        zone_lo = 400; zone_hi = 1600; glitch_mod = 0;
        run_case(1'b1);
        // directed: never an error, rising search exhausts budget (R6)
        zone_lo = 0; zone_hi = 0; glitch_mod = 0;
        run_case(1'b0);
        // directed: error never clears, falling search exhausts budget (R6 R9)
        zone_lo = 600; sticky = 1;
        run_case(1'b0);
        sticky = 0;
        // random windows
        for (int k = 0; k < 6; k++) begin
            zone_lo     = 200 + ($urandom % 3800);
            zone_hi     = zone_lo + 300 + ($urandom % 4700);
            glitch_mod  = ($urandom % 2) ? 0 : 15 + ($urandom % 26);
            glitch_seed = $urandom % 64;
            run_case(k == 2);
        end
        finish_up();
    end

endmodule